// File: doc/BRIEF.md
# Instruction Hint Classifier and Pause Throttle

This unit sits next to the decode stage of a 32-bit base-integer RISC-V core. Every cycle in which the decode stage offers a valid instruction word, the unit sorts the word into one of ten hint classes. The classes are: not a hint, pause, four non-temporal locality levels, semihosting entry marker, semihosting exit marker, standard-reserved hint, and custom hint. The classification appears on registered outputs one cycle later.

The unit only produces side outputs that affect the microarchitecture. The core still retires every hint as an ordinary dead instruction: it writes x0, or it runs a fence with a null ordering set. Nothing traps, and no register or PC value depends on this unit.

Two hints have an effect. A pause raises a fetch-stall output for a programmed number of cycles, and an external flush cuts that stall short. A non-temporal hint stores its locality level. The next memory access then receives that level on a one-shot tag output, and the stored level is cleared.

Top module: `hint_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, class_valid_o, fetch_stall_o and mem_ntl_valid_o are 0, and class_o and mem_ntl_level_o are 0.
- R2: After every rising clock edge, class_valid_o equals the instr_valid value sampled at that edge. class_o gives the class of the word sampled at that edge. The class encoding is 0 none, 1 pause, 2 NTL.P1, 3 NTL.PALL, 4 NTL.S1, 5 NTL.ALL, 6 semihosting entry, 7 semihosting exit, 8 standard-reserved, 9 custom. When instr_valid is low, class_o is 0 and the word has no effect.
- R3: The pause class applies only to the exact word 0x0100000F. That word is a FENCE (opcode 0x0F, funct3 0) with rd=rs1=x0, fm=0, predecessor set [27:24] equal to write only (0001), and successor set [23:20] equal to 0. A fence with predecessor and successor both nonzero is class 0.
- R4: ADD (opcode 0x33, funct3 0, funct7 0) with rd=x0, rs1=x0 and rs2 equal to x2, x3, x4 or x5 gives classes 2, 3, 4 and 5. ADD with rd=x0 and any other rs1/rs2 pair, including rs2=x1 and rs2=x6, gives class 8.
- R5: SLLI (funct3 1, funct7 0) with rd=x0, rs1=x0 and shamt=31 gives class 6. SRAI (funct3 5, funct7 0x20) with rd=x0, rs1=x0 and shamt=7 gives class 7. All other rd=x0 shift-immediate forms give class 9, including shamt 30 and shamt 6.
- R6: SLTI, SLTIU (opcode 0x13, funct3 2 and 3), SLT and SLTU (opcode 0x33, funct3 2 and 3, funct7 0) with rd=x0 give class 9.
- R7: LUI (0x37), AUIPC (0x17), XORI, ORI and ANDI with rd=x0 give class 8. So do the register forms SUB, SLL, SRL, SRA, XOR, OR and AND with rd=x0. ADDI with rd=x0 gives class 8 unless rs1=x0 and imm=0. That form is the NOP 0x00000013 and gives class 0.
- R8: A FENCE with fm [31:28] equal to 0, a zero predecessor or successor set, and any rd/rs1, other than the pause word, gives class 8.
- R9: Any non-fence word whose rd field [11:7] is nonzero gives class 0. So does any word with another opcode, and any invalid shift or register-form funct7.
- R10: When a pause is accepted with pause_cycles=N, fetch_stall_o is high for exactly N consecutive cycles starting the cycle after acceptance. N=0 gives no stall. A new pause reloads the count.
- R11: A high flush at a clock edge clears fetch_stall_o after that edge. Flush wins over a pause accepted at the same edge.
- R12: A non-temporal hint stores its level (0 P1, 1 PALL, 2 S1, 3 ALL). The first later cycle with mem_valid high raises mem_ntl_valid_o for one cycle, carrying that level, and clears the stored level. A newer non-temporal hint replaces an unconsumed level. A memory access with nothing stored leaves mem_ntl_valid_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Decode stage offers instr this cycle |
| instr | input | 32 | Instruction word |
| mem_valid | input | 1 | A load or store issues this cycle |
| flush | input | 1 | Releases any pause stall |
| pause_cycles | input | CNT_W | Stall length applied to each pause |
| class_valid_o | output | 1 | Registered copy of instr_valid |
| class_o | output | 4 | Registered hint class |
| fetch_stall_o | output | 1 | Fetch throttle request |
| mem_ntl_valid_o | output | 1 | Memory access is tagged with a non-temporal level |
| mem_ntl_level_o | output | 2 | Level carried by the tag |

## Verification
The bench builds the unit with CNT_W=4. This lets it reach the largest stall length (15) and the zero-length case in a few cycles. It sweeps the classifier over every funct3 of six opcodes. For each, it combines three funct7 patterns, zero and nonzero rd and rs1, and the rs2/shamt values around each named code point. The sweep covers the fence predecessor and successor fields as well as the NOP, and every result is compared with an arithmetic model of the requirements. Directed sequences then exercise stall length, reload, flush priority and the one-shot non-temporal tag.

// File: rtl/hint_pkg.sv
// Shared constants and the hint class type for the hint unit.
// Assumes the 32-bit base-integer encoding with standard field positions.
package hint_pkg;
    localparam int ILEN   = 32;
    localparam int NTL_W  = 2;
    localparam int CLS_W  = 4;

    localparam logic [6:0] OPC_LUI   = 7'h37;
    localparam logic [6:0] OPC_AUIPC = 7'h17;
    localparam logic [6:0] OPC_IMM   = 7'h13;
    localparam logic [6:0] OPC_REG   = 7'h33;
    localparam logic [6:0] OPC_FENCE = 7'h0F;

    localparam logic [ILEN-1:0] PAUSE_WORD = 32'h0100000F;
    localparam logic [4:0] SEMI_ENTER_SHAMT = 5'd31;
    localparam logic [4:0] SEMI_EXIT_SHAMT  = 5'd7;

    typedef enum logic [CLS_W-1:0] {
        HC_NONE       = 4'd0,
        HC_PAUSE      = 4'd1,
        HC_NTL_P1     = 4'd2,
        HC_NTL_PALL   = 4'd3,
        HC_NTL_S1     = 4'd4,
        HC_NTL_ALL    = 4'd5,
        HC_SEMI_ENTER = 4'd6,
        HC_SEMI_EXIT  = 4'd7,
        HC_STD        = 4'd8,
        HC_CUSTOM     = 4'd9
    } hint_class_e;
endpackage

// File: rtl/hint_decode.sv
// Combinational hint classifier.
// Maps one instruction word to a hint class and, for non-temporal hints,
// to a locality level. Assumes nothing about the valid strobe.
module hint_decode
    import hint_pkg::*;
(
    input  logic [ILEN-1:0]  word,
    output hint_class_e      cls,
    output logic [NTL_W-1:0] ntl_lvl
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       rd_zero;
    logic [3:0] fm;
    logic [3:0] pred;
    logic [3:0] succ;

    assign opc     = word[6:0];
    assign rd_zero = (word[11:7] == 5'd0);
    assign f3      = word[14:12];
    assign rs1     = word[19:15];
    assign rs2     = word[24:20];
    assign f7      = word[31:25];
    assign fm      = word[31:28];
    assign pred    = word[27:24];
    assign succ    = word[23:20];

    // Classify the word by opcode, function fields and operand registers.
    always_comb begin
        cls     = HC_NONE;
        ntl_lvl = '0;
        unique case (opc)
            OPC_LUI, OPC_AUIPC: begin
                if (rd_zero) cls = HC_STD;
            end
            OPC_IMM: begin
                if (rd_zero) begin
                    unique case (f3)
                        3'd0: if (rs1 != 5'd0 || word[31:20] != 12'd0) cls = HC_STD;
                        3'd2, 3'd3: cls = HC_CUSTOM;
                        3'd4, 3'd6, 3'd7: cls = HC_STD;
                        3'd1: begin
                            if (f7 == 7'h00)
                                cls = (rs1 == 5'd0 && rs2 == SEMI_ENTER_SHAMT) ? HC_SEMI_ENTER : HC_CUSTOM;
                        end
                        3'd5: begin
                            if (f7 == 7'h00)
                                cls = HC_CUSTOM;
                            else if (f7 == 7'h20)
                                cls = (rs1 == 5'd0 && rs2 == SEMI_EXIT_SHAMT) ? HC_SEMI_EXIT : HC_CUSTOM;
                        end
                        default: cls = HC_NONE;
                    endcase
                end
            end
            OPC_REG: begin
                if (rd_zero) begin
                    if (f7 == 7'h00) begin
                        if (f3 == 3'd0 && rs1 == 5'd0 && rs2 >= 5'd2 && rs2 <= 5'd5) begin
                            ntl_lvl = NTL_W'(rs2 - 5'd2);
                            cls     = hint_class_e'(CLS_W'(HC_NTL_P1) + CLS_W'(rs2 - 5'd2));
                        end else if (f3 == 3'd2 || f3 == 3'd3) begin
                            cls = HC_CUSTOM;
                        end else begin
                            cls = HC_STD;
                        end
                    end else if (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5)) begin
                        cls = HC_STD;
                    end
                end
            end
            OPC_FENCE: begin
                if (f3 == 3'd0) begin
                    if (word == PAUSE_WORD)
                        cls = HC_PAUSE;
                    else if (fm == 4'd0 && (pred == 4'd0 || succ == 4'd0))
                        cls = HC_STD;
                end
            end
            default: cls = HC_NONE;
        endcase
    end
endmodule

// File: rtl/hint_throttle.sv
// Pause throttle: a down-counter loaded on each accepted pause.
// The stall request is high while the count is nonzero. Flush clears it
// and takes priority over a load at the same edge.
module hint_throttle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             flush,
    input  logic [CNT_W-1:0] len,
    output logic             stall
);
    logic [CNT_W-1:0] remain_q;

    // Load, count down, or clear the remaining stall cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                remain_q <= '0;
        else if (flush)            remain_q <= '0;
        else if (start)            remain_q <= len;
        else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
    end

    assign stall = (remain_q != '0);
endmodule

// File: rtl/hint_ntl_track.sv
// Non-temporal level tracker: holds one pending locality level.
// The next memory access uses up the level and is tagged with it. A new hint
// replaces the held level and wins over a consumption at the same edge.
module hint_ntl_track
    import hint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic [NTL_W-1:0] set_lvl,
    input  logic             mem_valid,
    output logic             tag_valid,
    output logic [NTL_W-1:0] tag_lvl
);
    logic             held_q;
    logic [NTL_W-1:0] lvl_q;

    // Hold the pending level until a memory access takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            lvl_q  <= '0;
        end else if (set) begin
            held_q <= 1'b1;
            lvl_q  <= set_lvl;
        end else if (mem_valid) begin
            held_q <= 1'b0;
        end
    end

    // Register the one-shot tag for the consuming access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_valid <= 1'b0;
            tag_lvl   <= '0;
        end else begin
            tag_valid <= mem_valid && held_q;
            tag_lvl   <= (mem_valid && held_q) ? lvl_q : '0;
        end
    end
endmodule

// File: rtl/hint_unit.sv
// Hint unit top level: classifies the decode word, registers the class,
// drives the pause throttle and the non-temporal tracker.
// Assumes instr is stable while instr_valid is high at the clock edge.
module hint_unit
    import hint_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic             mem_valid,
    input  logic             flush,
    input  logic [CNT_W-1:0] pause_cycles,
    output logic             class_valid_o,
    output logic [3:0]       class_o,
    output logic             fetch_stall_o,
    output logic             mem_ntl_valid_o,
    output logic [1:0]       mem_ntl_level_o
);
    hint_class_e      dec_cls;
    logic [NTL_W-1:0] dec_lvl;
    logic             is_pause;
    logic             is_ntl;

    hint_decode u_dec (
        .word    (instr),
        .cls     (dec_cls),
        .ntl_lvl (dec_lvl)
    );

    assign is_pause = instr_valid && (dec_cls == HC_PAUSE);
    assign is_ntl   = instr_valid && (dec_cls >= HC_NTL_P1) && (dec_cls <= HC_NTL_ALL);

    // Register the class and its valid flag one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_valid_o <= 1'b0;
            class_o       <= '0;
        end else begin
            class_valid_o <= instr_valid;
            class_o       <= instr_valid ? CLS_W'(dec_cls) : CLS_W'(HC_NONE);
        end
    end

    hint_throttle #(.CNT_W(CNT_W)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (is_pause),
        .flush (flush),
        .len   (pause_cycles),
        .stall (fetch_stall_o)
    );

    hint_ntl_track u_ntl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (is_ntl),
        .set_lvl   (dec_lvl),
        .mem_valid (mem_valid),
        .tag_valid (mem_ntl_valid_o),
        .tag_lvl   (mem_ntl_level_o)
    );
endmodule

// File: rtl/hint_unit_chk.sv
// Checker for hint_unit. Relates its ports over time and is attached with bind.
module hint_unit_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [31:0]      instr,
    input logic             mem_valid,
    input logic             flush,
    input logic [CNT_W-1:0] pause_cycles,
    input logic             class_valid_o,
    input logic [3:0]       class_o,
    input logic             fetch_stall_o,
    input logic             mem_ntl_valid_o,
    input logic [1:0]       mem_ntl_level_o
);
    AST_IDLE_NO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(instr_valid) |-> (class_o == 4'd0 && !class_valid_o)); // R2

    AST_CLASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        class_o <= 4'd9); // R2

    AST_PAUSE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (class_o == 4'd1 && $past(pause_cycles) != '0 && !$past(flush)) |-> fetch_stall_o); // R10

    AST_STALL_NEEDS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_stall_o) |-> (class_valid_o && class_o == 4'd1)); // R10

    AST_FLUSH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !fetch_stall_o); // R11

    AST_TAG_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ntl_valid_o |-> $past(mem_valid)); // R12

    AST_TAG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ntl_valid_o && $past(mem_ntl_valid_o)) |-> ($past(class_o) >= 4'd2 && $past(class_o) <= 4'd5)); // R12
endmodule

bind hint_unit hint_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .instr_valid     (instr_valid),
    .instr           (instr),
    .mem_valid       (mem_valid),
    .flush           (flush),
    .pause_cycles    (pause_cycles),
    .class_valid_o   (class_valid_o),
    .class_o         (class_o),
    .fetch_stall_o   (fetch_stall_o),
    .mem_ntl_valid_o (mem_ntl_valid_o),
    .mem_ntl_level_o (mem_ntl_level_o)
);

// File: tb/tb_hint_unit.sv
// Bench for hint_unit: classifier sweep against an arithmetic model,
// then directed throttle and non-temporal sequences.
module tb_hint_unit;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic          mem_valid = 1'b0;
    logic          flush = 1'b0;
    logic [CW-1:0] pause_cycles = '0;
    logic          class_valid_o;
    logic [3:0]    class_o;
    logic          fetch_stall_o;
    logic          mem_ntl_valid_o;
    logic [1:0]    mem_ntl_level_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    hint_unit #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .mem_valid(mem_valid), .flush(flush), .pause_cycles(pause_cycles),
        .class_valid_o(class_valid_o), .class_o(class_o),
        .fetch_stall_o(fetch_stall_o), .mem_ntl_valid_o(mem_ntl_valid_o),
        .mem_ntl_level_o(mem_ntl_level_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Arithmetic model of the class encoding from the requirements.
    function automatic int model(input logic [31:0] w);
        int op, f3, f7, r1, r2;
        op = int'(w[6:0]); f3 = int'(w[14:12]); f7 = int'(w[31:25]);
        r1 = int'(w[19:15]); r2 = int'(w[24:20]);
        if (op == 'h0F && f3 == 0) begin
            if (w == 32'h0100000F) return 1;
            if (w[31:28] == 0 && (w[27:24] == 0 || w[23:20] == 0)) return 8;
            return 0;
        end
        if (w[11:7] != 0) return 0;
        if (op == 'h37 || op == 'h17) return 8;
        if (op == 'h13) begin
            if (f3 == 0) return (r1 == 0 && w[31:20] == 0) ? 0 : 8;
            if (f3 == 2 || f3 == 3) return 9;
            if (f3 == 4 || f3 == 6 || f3 == 7) return 8;
            if (f3 == 1) return (f7 != 0) ? 0 : ((r1 == 0 && r2 == 31) ? 6 : 9);
            if (f7 == 0) return 9;
            if (f7 == 'h20) return (r1 == 0 && r2 == 7) ? 7 : 9;
            return 0;
        end
        if (op == 'h33) begin
            if (f7 == 0) begin
                if (f3 == 0) return (r1 == 0 && r2 >= 2 && r2 <= 5) ? r2 : 8;
                if (f3 == 2 || f3 == 3) return 9;
                return 8;
            end
            if (f7 == 'h20 && (f3 == 0 || f3 == 5)) return 8;
            return 0;
        end
        return 0;
    endfunction

    function automatic string tag_of(input logic [31:0] w, input int c);
        if (c == 1) return "R3";
        if (c >= 2 && c <= 5) return "R4";
        if (c == 6 || c == 7) return "R5";
        if (c == 9) return "R6";
        if (c == 8) return (w[6:0] == 7'h0F) ? "R8" : "R7";
        return (w[11:7] != 0) ? "R9" : "R7";
    endfunction

    // Present one word for one edge; returns at the following falling edge.
    task automatic issue(input logic [31:0] w);
        instr = w; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic mem_op();
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
    endtask

    task automatic classify(input string req, input logic [31:0] w, input int exp);
        issue(w);
        chk(req, $sformatf("class of %08h", w), int'(class_o), exp);
    endtask

    task automatic stall_len(input string req, input int n);
        int seen;
        pause_cycles = CW'(n);
        issue(32'h0100000F);
        seen = 0;
        while (fetch_stall_o && seen < 40) begin
            seen++;
            @(negedge clk);
        end
        chk(req, $sformatf("stall length for %0d", n), seen, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [6:0] ops [6];
        logic [6:0] f7s [3];
        logic [4:0] r2s [12];
        ops = '{7'h13, 7'h33, 7'h37, 7'h17, 7'h0F, 7'h03};
        f7s = '{7'h00, 7'h20, 7'h01};
        r2s = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd16, 5'd17, 5'd30, 5'd31};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "class_valid in reset", int'(class_valid_o), 0);
        chk("R1", "stall in reset", int'(fetch_stall_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "class after reset", int'(class_o), 0);
        chk("R1", "tag after reset", int'(mem_ntl_valid_o), 0);
        chk("R1", "tag level after reset", int'(mem_ntl_level_o), 0);

        // R2: valid low ignores a pause word
        pause_cycles = CW'(5);
        instr = 32'h0100000F; instr_valid = 1'b0;
        @(negedge clk);
        chk("R2", "class with valid low", int'(class_o), 0);
        chk("R2", "class_valid with valid low", int'(class_valid_o), 0);
        chk("R2", "stall with valid low", int'(fetch_stall_o), 0);
        issue(32'h00000033);
        chk("R2", "class_valid follows strobe", int'(class_valid_o), 1);
        pause_cycles = '0;

        // Sweep against the model
        foreach (ops[oi]) for (int f3 = 0; f3 < 8; f3++) foreach (f7s[fi])
            for (int rd = 0; rd < 2; rd++) for (int r1 = 0; r1 < 2; r1++) foreach (r2s[ri]) begin
                logic [31:0] w;
                int e;
                w = {f7s[fi], r2s[ri], 5'(r1 * 3), 3'(f3), 5'(rd * 5), ops[oi]};
                e = model(w);
                classify(tag_of(w, e), w, e);
            end

        // Directed code points and neighbours
        classify("R7", 32'h00000013, 0);
        classify("R7", 32'h00100013, 8);
        classify("R7", 32'h00008013, 8);
        classify("R3", 32'h0100000F, 1);
        classify("R3", 32'h0110000F, 0);
        classify("R8", 32'h0100800F, 8);
        classify("R8", 32'h0000000F, 8);
        classify("R8", 32'h8100000F, 0);
        classify("R4", 32'h00200033, 2);
        classify("R4", 32'h00300033, 3);
        classify("R4", 32'h00400033, 4);
        classify("R4", 32'h00500033, 5);
        classify("R4", 32'h00100033, 8);
        classify("R4", 32'h00600033, 8);
        classify("R5", 32'h01F01013, 6);
        classify("R5", 32'h01E01013, 9);
        classify("R5", 32'h40705013, 7);
        classify("R5", 32'h40605013, 9);
        classify("R6", 32'h00002033, 9);
        classify("R6", 32'h00003013, 9);
        classify("R9", 32'h00200133, 0);
        classify("R9", 32'h0FF00093, 0);

        // R10: stall lengths, zero, maximum, reload
        stall_len("R10", 3);
        stall_len("R10", 0);
        stall_len("R10", 1);
        stall_len("R10", 15);
        pause_cycles = CW'(4);
        issue(32'h0100000F);
        @(negedge clk);
        issue(32'h0100000F);
        chk("R10", "stall after reload", int'(fetch_stall_o), 1);
        repeat (3) @(negedge clk);
        chk("R10", "stall 4th cycle of reload", int'(fetch_stall_o), 1);
        @(negedge clk);
        chk("R10", "stall ends after reload", int'(fetch_stall_o), 0);

        // R11: flush release and priority
        pause_cycles = CW'(10);
        issue(32'h0100000F);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R11", "stall after flush", int'(fetch_stall_o), 0);
        flush = 1'b1;
        issue(32'h0100000F);
        flush = 1'b0;
        chk("R11", "flush beats pause", int'(fetch_stall_o), 0);
        pause_cycles = '0;

        // R12: one-shot non-temporal tag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mem_op();
        chk("R12", "tag with nothing held", int'(mem_ntl_valid_o), 0);
        issue(32'h00400033);
        @(negedge clk);
        mem_op();
        chk("R12", "tag after S1", int'(mem_ntl_valid_o), 1);
        chk("R12", "level after S1", int'(mem_ntl_level_o), 2);
        mem_op();
        chk("R12", "tag cleared after use", int'(mem_ntl_valid_o), 0);
        issue(32'h00200033);
        issue(32'h00500033);
        mem_op();
        chk("R12", "tag after overwrite", int'(mem_ntl_valid_o), 1);
        chk("R12", "level after overwrite", int'(mem_ntl_level_o), 3);
        issue(32'h00300033);
        mem_op();
        chk("R12", "level PALL", int'(mem_ntl_level_o), 1);
        issue(32'h00200033);
        mem_op();
        chk("R12", "level P1", int'(mem_ntl_level_o), 0);
        chk("R12", "tag P1", int'(mem_ntl_valid_o), 1);

        finish_run();
    end
endmodule